// File: doc/BRIEF.md
# Barrel distortion coordinate mapper

This block produces source sampling coordinates for lens barrel-distortion correction. It runs in step with a video raster. Each cycle it can take a pixel strobe, a line-end strobe and a frame-start strobe. It keeps the centred column and row of the current output pixel (`x`, `y`) and their squares. The squares are updated by adding `2v+1` on each step, so no per-pixel square multiplier is needed.

For every pixel it forms a radial term from the scaled sum of squares. That term indexes a 16-entry magnification table, and the result is linearly interpolated between neighbouring entries. Both centred coordinates are then multiplied by the magnification. The corrected coordinates leave the block with eight fractional bits and a valid flag. Pixel fetch and pixel-value interpolation belong to the stages downstream.

Top module: `lens_warp_addr`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0. `out_x` and `out_y` are 0 until the first pixel result leaves the pipeline.
- R2: A pixel strobe sampled on a rising edge gives `out_valid` high after the third rising edge that follows. Gaps between pixels are kept exactly in the output stream.
- R3: Each pixel strobe advances `x` by one. The square of `x` is kept equal to `x*x` by adding `2x+1` to it.
- R4: A line-end strobe reloads `x` to `-(COLS/2)` and its square to the direct product of that value with itself. It also advances `y` by one and adds `2y+1` to the square of `y`.
- R5: A frame-start strobe, and reset, set `x` to `-(COLS/2)` and `y` to `-(ROWS/2)`, with both squares set to match.
- R6: The radial term is `((x*x + y*y) * K) >> KSHIFT`, saturated at 4095. The radial term is 12 bits wide.
- R7: Table entry `i` holds `256 + 4*i*i`, an unsigned value with 8 fractional bits. Bits [11:8] of the radial term select entry `lo`. The next entry up is `hi`; for index 15, `hi` is entry 15 itself. Bits [7:0] form the weight `f`. The magnification is `lo + ((hi - lo) * f >> 8)`.
- R8: `out_x = x * mag` and `out_y = y * mag` are signed two's-complement values with 8 fractional bits.
- R9: A pixel strobe in the same cycle as a line-end or frame-start strobe is emitted with the coordinates held before that cycle. The strobe's reload then wins over the pixel advance. Frame-start takes priority over line-end.
- R10: In a cycle with no strobe, `x`, `y` and both squares stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | An active output pixel is requested this cycle |
| line_end | input | 1 | The raster has reached the end of the visible columns |
| frame_start | input | 1 | A new frame begins |
| out_valid | output | 1 | `out_x`/`out_y` hold a result |
| out_x | output | CW+MW+1 (24) | Corrected column, signed, 8 fractional bits |
| out_y | output | CW+MW+1 (24) | Corrected row, signed, 8 fractional bits |

## Verification
The bench aims at the frame corners, where the radial term saturates and the top table entry has to interpolate against itself. A design that indexes past the table there, or wraps the radial term instead of clamping it, gives a corner magnification that is far too small. The bench also drives line-end and frame-start in the same cycle as a pixel. A design that applies the reload before emitting that pixel shifts the last pixel of each row onto the next row. Idle gaps and a single isolated pixel expose any change to the fixed latency, and any advance of the coordinates on cycles without a strobe.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  // Magnification table entry: unity gain plus a quadratic bend.
  function automatic int mag_entry(input int i, input int base, input int curve);
    return base + curve * i * i;
  endfunction
endpackage

// File: rtl/lwa_coord_gen.sv
module lwa_coord_gen #(
  parameter int CW = 11,
  parameter int SW = 2 * CW - 1,
  parameter int X0 = -320,
  parameter int Y0 = -240
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic                 line_end,
  input  logic                 frame_start,
  output logic signed [CW-1:0] x,
  output logic signed [CW-1:0] y,
  output logic        [SW-1:0] sx,
  output logic        [SW-1:0] sy
);
  localparam logic signed [CW-1:0] X0V  = CW'(X0);
  localparam logic signed [CW-1:0] Y0V  = CW'(Y0);
  localparam logic        [SW-1:0] X0SQ = SW'(X0 * X0);
  localparam logic        [SW-1:0] Y0SQ = SW'(Y0 * Y0);

  // 2v+1, sign-extended to the square width (modular add keeps it exact)
  logic [SW-1:0] xstep, ystep;
  assign xstep = {{(SW-CW-1){x[CW-1]}}, x, 1'b1};
  assign ystep = {{(SW-CW-1){y[CW-1]}}, y, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      x  <= X0V;
      sx <= X0SQ;
      y  <= Y0V;
      sy <= Y0SQ;
    end else if (line_end) begin
      x  <= X0V;
      sx <= X0SQ;
      y  <= y + CW'(1);
      sy <= sy + ystep;
    end else if (pix_valid) begin
      x  <= x + CW'(1);
      sx <= sx + xstep;
    end
  end
endmodule

// File: rtl/lwa_radial.sv
module lwa_radial #(
  parameter int CW     = 11,
  parameter int SW     = 2 * CW - 1,
  parameter int KW     = 8,
  parameter int K      = 16,
  parameter int KSHIFT = 9,
  parameter int RW     = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [CW-1:0] in_x,
  input  logic signed [CW-1:0] in_y,
  input  logic        [SW-1:0] in_sx,
  input  logic        [SW-1:0] in_sy,
  output logic                 a_valid,
  output logic signed [CW-1:0] a_x,
  output logic signed [CW-1:0] a_y,
  output logic        [RW-1:0] a_rad
);
  localparam int              PW   = SW + 1 + KW;
  localparam logic [KW-1:0]   KV   = KW'(K);
  localparam logic [PW-1:0]   RMAX = PW'((64'd1 << RW) - 64'd1);

  logic [SW:0]   sum;
  logic [PW-1:0] prod, scaled;

  assign sum    = {1'b0, in_sx} + {1'b0, in_sy};
  assign prod   = PW'(sum) * PW'(KV);
  assign scaled = prod >> KSHIFT;

  always_ff @(posedge clk) begin
    if (rst) a_valid <= 1'b0;
    else     a_valid <= in_valid;
    a_x   <= in_x;
    a_y   <= in_y;
    a_rad <= (scaled > RMAX) ? RMAX[RW-1:0] : scaled[RW-1:0];
  end
endmodule

// File: rtl/lwa_mag_lut.sv
module lwa_mag_lut #(
  parameter int CW    = 11,
  parameter int IDXW  = 4,
  parameter int FB    = 8,
  parameter int MW    = 12,
  parameter int BASE  = 256,
  parameter int CURVE = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   a_valid,
  input  logic signed [CW-1:0]   a_x,
  input  logic signed [CW-1:0]   a_y,
  input  logic [IDXW+FB-1:0]     a_rad,
  output logic                   c_valid,
  output logic signed [CW-1:0]   c_x,
  output logic signed [CW-1:0]   c_y,
  output logic [MW-1:0]          c_mag
);
  localparam int ENT = 2 ** IDXW;

  // Read-only table, two synchronous read ports (block RAM friendly)
  logic [MW-1:0] rom [ENT];
  initial begin
    for (int i = 0; i < ENT; i++) rom[i] = MW'(lwa_pkg::mag_entry(i, BASE, CURVE));
  end

  logic [IDXW-1:0] idx, idx_hi;
  assign idx    = a_rad[IDXW+FB-1:FB];
  assign idx_hi = (idx == IDXW'(ENT - 1)) ? idx : idx + IDXW'(1);

  // Stage B: table read
  logic                 b_valid;
  logic signed [CW-1:0] b_x, b_y;
  logic [MW-1:0]        b_lo, b_hi;
  logic [FB-1:0]        b_frac;

  always_ff @(posedge clk) begin
    if (rst) b_valid <= 1'b0;
    else     b_valid <= a_valid;
    b_x    <= a_x;
    b_y    <= a_y;
    b_lo   <= rom[idx];
    b_hi   <= rom[idx_hi];
    b_frac <= a_rad[FB-1:0];
  end

  // Stage C: linear interpolation between the two entries
  logic signed [MW:0]      diff;
  logic signed [MW+FB+1:0] wprod, msum;
  assign diff  = $signed({1'b0, b_hi}) - $signed({1'b0, b_lo});
  assign wprod = diff * $signed({1'b0, b_frac});
  assign msum  = $signed({{(FB+2){1'b0}}, b_lo}) + (wprod >>> FB);

  always_ff @(posedge clk) begin
    if (rst) c_valid <= 1'b0;
    else     c_valid <= b_valid;
    c_x   <= b_x;
    c_y   <= b_y;
    c_mag <= msum[MW-1:0];
  end
endmodule

// File: rtl/lwa_scale.sv
module lwa_scale #(
  parameter int CW = 11,
  parameter int MW = 12,
  parameter int OW = CW + MW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 c_valid,
  input  logic signed [CW-1:0] c_x,
  input  logic signed [CW-1:0] c_y,
  input  logic [MW-1:0]        c_mag,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_x,
  output logic signed [OW-1:0] out_y
);
  logic signed [MW:0]   mag_s;
  logic signed [OW-1:0] px, py;
  assign mag_s = $signed({1'b0, c_mag});
  assign px    = c_x * mag_s;
  assign py    = c_y * mag_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= c_valid;
      if (c_valid) begin
        out_x <= px;
        out_y <= py;
      end
    end
  end
endmodule

// File: rtl/lens_warp_addr.sv
module lens_warp_addr #(
  parameter int CW     = 11,
  parameter int COLS   = 640,
  parameter int ROWS   = 480,
  parameter int KW     = 8,
  parameter int K      = 16,
  parameter int KSHIFT = 9,
  parameter int IDXW   = 4,
  parameter int FB     = 8,
  parameter int MW     = 12,
  parameter int BASE   = 256,
  parameter int CURVE  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pix_valid,
  input  logic                      line_end,
  input  logic                      frame_start,
  output logic                      out_valid,
  output logic signed [CW+MW:0]     out_x,
  output logic signed [CW+MW:0]     out_y
);
  localparam int SW = 2 * CW - 1;
  localparam int RW = IDXW + FB;
  localparam int OW = CW + MW + 1;
  localparam int X0 = -(COLS / 2);
  localparam int Y0 = -(ROWS / 2);

  logic signed [CW-1:0] cur_x, cur_y, a_x, a_y, c_x, c_y;
  logic        [SW-1:0] cur_sx, cur_sy;
  logic                 a_valid, c_valid;
  logic        [RW-1:0] a_rad;
  logic        [MW-1:0] c_mag;

  lwa_coord_gen #(.CW(CW), .SW(SW), .X0(X0), .Y0(Y0)) u_coord (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_end(line_end),
    .frame_start(frame_start), .x(cur_x), .y(cur_y), .sx(cur_sx), .sy(cur_sy)
  );

  lwa_radial #(.CW(CW), .SW(SW), .KW(KW), .K(K), .KSHIFT(KSHIFT), .RW(RW)) u_rad (
    .clk(clk), .rst(rst), .in_valid(pix_valid), .in_x(cur_x), .in_y(cur_y),
    .in_sx(cur_sx), .in_sy(cur_sy), .a_valid(a_valid), .a_x(a_x), .a_y(a_y),
    .a_rad(a_rad)
  );

  lwa_mag_lut #(.CW(CW), .IDXW(IDXW), .FB(FB), .MW(MW), .BASE(BASE), .CURVE(CURVE)) u_lut (
    .clk(clk), .rst(rst), .a_valid(a_valid), .a_x(a_x), .a_y(a_y), .a_rad(a_rad),
    .c_valid(c_valid), .c_x(c_x), .c_y(c_y), .c_mag(c_mag)
  );

  lwa_scale #(.CW(CW), .MW(MW), .OW(OW)) u_scale (
    .clk(clk), .rst(rst), .c_valid(c_valid), .c_x(c_x), .c_y(c_y), .c_mag(c_mag),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );
endmodule

// File: rtl/lwa_checks.sv
module lwa_checks #(
  parameter int CW   = 11,
  parameter int SW   = 2 * CW - 1,
  parameter int MW   = 12,
  parameter int X0   = -320,
  parameter int Y0   = -240,
  parameter int BASE = 256
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pix_valid,
  input logic                 line_end,
  input logic                 frame_start,
  input logic signed [CW-1:0] cur_x,
  input logic signed [CW-1:0] cur_y,
  input logic        [SW-1:0] cur_sx,
  input logic        [SW-1:0] cur_sy,
  input logic                 c_valid,
  input logic        [MW-1:0] c_mag,
  input logic                 out_valid
);
  localparam logic signed [CW-1:0] X0V  = CW'(X0);
  localparam logic signed [CW-1:0] Y0V  = CW'(Y0);
  localparam logic        [SW-1:0] Y0SQ = SW'(Y0 * Y0);

  logic signed [2*CW-1:0] xx, yy;
  assign xx = cur_x * cur_x;
  assign yy = cur_y * cur_y;

  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst)            warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4) |-> (out_valid == $past(pix_valid, 4)));

  p_square_r3: assert property (@(posedge clk) disable iff (rst)
    ($unsigned(xx) == {1'b0, cur_sx}) && ($unsigned(yy) == {1'b0, cur_sy}));

  p_line_r4: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_start) |=> (cur_x == X0V) && ((cur_y - $past(cur_y)) == CW'(1)));

  p_frame_r5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cur_x == X0V) && (cur_y == Y0V) && (cur_sy == Y0SQ));

  p_mag_floor_r7: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> (c_mag >= MW'(BASE)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!pix_valid && !line_end && !frame_start) |=> $stable(cur_x) && $stable(cur_y)
      && $stable(cur_sx) && $stable(cur_sy));
endmodule

bind lens_warp_addr lwa_checks #(
  .CW(CW), .SW(SW), .MW(MW), .X0(X0), .Y0(Y0), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_end(line_end),
  .frame_start(frame_start), .cur_x(cur_x), .cur_y(cur_y), .cur_sx(cur_sx),
  .cur_sy(cur_sy), .c_valid(c_valid), .c_mag(c_mag), .out_valid(out_valid)
);

// File: tb/sim_lens_warp_addr.sv
module sim_lens_warp_addr;
  localparam int COLS = 32;
  localparam int ROWS = 16;
  localparam int KC   = 255;
  localparam int KSH  = 4;
  localparam int OW   = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid = 1'b0, line_end = 1'b0, frame_start = 1'b0;
  logic out_valid;
  logic signed [OW-1:0] out_x, out_y;

  always #4 clk = ~clk;

  lens_warp_addr #(.COLS(COLS), .ROWS(ROWS), .K(KC), .KSHIFT(KSH)) u0 (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_end(line_end),
    .frame_start(frame_start), .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  int checks = 0, errors = 0;
  int mx, my;
  int ex_x [2048];
  int ex_y [2048];
  int cap_x [4096];
  int cap_y [4096];
  int nexp = 0, ncap = 0, base = 0;

  always @(negedge clk) begin
    if (out_valid && ncap < 4096) begin
      cap_x[ncap] = int'(out_x);
      cap_y[ncap] = int'(out_y);
      ncap++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int tab(input int i);
    return 256 + 4 * i * i;
  endfunction

  function automatic int exp_mag(input int x, input int y);
    longint r;
    int idx, fr, lo, hi;
    r = (longint'(x * x + y * y) * KC) >>> KSH;
    if (r > 4095) r = 4095;
    idx = int'(r) / 256;
    fr  = int'(r) % 256;
    lo  = tab(idx);
    hi  = tab(idx == 15 ? 15 : idx + 1);
    return lo + (((hi - lo) * fr) >>> 8);
  endfunction

  // One raster cycle: drive at a falling edge, update the model per R3/R4/R5/R9/R10
  task automatic cyc(input bit pv, input bit le, input bit fs);
    pix_valid = pv; line_end = le; frame_start = fs;
    if (pv) begin
      ex_x[nexp] = mx * exp_mag(mx, my);
      ex_y[nexp] = my * exp_mag(mx, my);
      nexp++;
    end
    if (fs) begin mx = -(COLS / 2); my = -(ROWS / 2); end
    else if (le) begin mx = -(COLS / 2); my = my + 1; end
    else if (pv) mx = mx + 1;
    @(negedge clk);
    pix_valid = 0; line_end = 0; frame_start = 0;
  endtask

  task automatic clear();
    nexp = 0;
    base = ncap;
  endtask

  task automatic cmp_stream(input string tag);
    repeat (8) @(negedge clk);
    chk({tag, " count"}, ncap - base, nexp);
    for (int i = 0; i < nexp; i++) begin
      chk({tag, " x"}, cap_x[base + i], ex_x[i]);
      chk({tag, " y"}, cap_y[base + i], ex_y[i]);
    end
  endtask

  task automatic t_reset();
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 out_x in reset", int'(out_x), 0);
    rst = 0;
    mx = -(COLS / 2); my = -(ROWS / 2);
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 out_y after reset", int'(out_y), 0);
  endtask

  task automatic t_latency();
    clear();
    repeat (3) @(negedge clk);
    cyc(1, 0, 0);
    repeat (2) @(negedge clk);
    chk("R2 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid at latency", int'(out_valid), 1);
    @(negedge clk);
    chk("R2 single pulse", int'(out_valid), 0);
    cmp_stream("R2 value");
  endtask

  task automatic t_frame();
    clear();
    cyc(0, 0, 1);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) cyc(1, 0, 0);
      cyc(0, 1, 0);
    end
    cmp_stream("R3 R4 R8 frame");
    // corner: radial term saturates, top entry interpolates with itself
    chk("R6 R7 corner x", cap_x[base], -16 * 1156);
    chk("R6 R7 corner y", cap_y[base], -8 * 1156);
    // centre row 8, column x=1: radial 15 -> mag 256
    chk("R7 near centre x", cap_x[base + 8 * COLS + 17], 256);
    chk("R5 R8 centre row y", cap_y[base + 8 * COLS + 17], 0);
  endtask

  task automatic t_gaps();
    clear();
    cyc(0, 0, 1);
    for (int i = 0; i < 12; i++) begin
      cyc(1, 0, 0);
      for (int g = 0; g < (i % 3); g++) cyc(0, 0, 0);
    end
    cyc(0, 1, 0);
    repeat (4) cyc(0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0);
    cmp_stream("R10 R2 gaps");
  endtask

  task automatic t_coincide();
    clear();
    cyc(0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0);
    cyc(1, 1, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0);
    cyc(1, 1, 1);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0);
    cmp_stream("R9 coincide");
    chk("R9 last of line keeps row", cap_y[base + 6], -8 * exp_mag(-10, -8));
    chk("R9 frame beats line", cap_y[base + 11], -8 * exp_mag(-16, -8));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_frame();
    t_gaps();
    t_coincide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule